// File: doc/BRIEF.md
# Frequency-Window Carrier Detector

This block decides whether a usable carrier is arriving on a receive line. Its input is a one-bit square wave that an external comparator with hysteresis has already cut from the analog signal. The block runs on the oscillator clock. It times every input cycle, measured from one rising edge to the next, in oscillator clocks. A cycle is accepted only when its length falls inside a narrow window around sixteen clocks.

Accepted and rejected cycles are gathered into fixed reference slots. Each slot is sixteen oscillator clocks long, and each slot leaves one vote in a short history. A majority over that history, with separate thresholds to enter and to leave, drives an active-low detect output.

Noise, harmonics and sub-harmonics therefore never produce a detection. A real carrier is reported after about nine to fifteen reference periods, and its loss is reported after a similar delay.

Top module: `carrier_window_detector`

## Requirements
- R1: While `rstN` is low, and after its release until a carrier is accepted, `detectN` is 1 (not detected), and the vote history holds no accepted slot.
- R2: A cycle is in-window when the distance between two consecutive synchronized rising edges of `carrierIn` is at least 14 and at most 18 clocks. Periods of 13 or 19 clocks are out-of-window. The first rising edge after reset only starts a measurement.
- R3: The period counter stops at 31 and does not wrap. A cycle of 31 or more clocks (for example 48) counts as out-of-window, and a steady stream of such cycles never asserts detection.
- R4: Every 16 clocks a slot closes and shifts one vote into a 15-entry history. The vote is 1 when at least one in-window cycle and no out-of-window cycle ended during that slot, and 0 otherwise.
- R5: `detectN` goes to 0 when 9 or more of the 15 votes are 1. For a steady in-window carrier this happens between 8×16 and 15×16+8 clocks after the first in-window cycle ends at the input pin.
- R6: `detectN` returns to 1 when 9 or more of the 15 votes are 0. It stays 0 while the in-window carrier continues. When the input stops toggling, `detectN` rises between 6×16 and 15×16+8 clocks after the last rising edge.
- R7: A steady input with periods of 4, 13, 19 or 48 clocks never drives `detectN` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| carrierIn | input | 1 | Shaped carrier from the external comparator, asynchronous |
| detectN | output | 1 | Active-low carrier detected |

## Verification
The hardest case to reach from the ports is a carrier at the edges of the window. At 18 clocks, some slots receive no edge at all and vote 0. At 14 clocks, some slots receive two edges. The decision has to ride through these vote patterns and still land inside the latency bounds. The stimulus table drives steady square waves at every period from 13 to 19 clocks. For each one the bench times the falling and rising edges of `detectN` against the first and last driven edges. It also drives very short and very long periods, which exercise the saturating counter. A directed test resets the block while it holds a detection.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  // Classification of a completed input cycle, one-cycle pulses
  typedef struct packed {
    logic validEnd;
    logic invalidEnd;
  } cycleEvt_t;

  // Strobes from control to the vote history in the datapath
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
  } histStrobe_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_LOCKED = 1'b1
  } detState_t;

endpackage

// File: rtl/cwd_datapath.sv
module cwd_datapath
  import cwd_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int MIN_PERIOD = 14,
  parameter int MAX_PERIOD = 18,
  parameter int HIST_LEN   = 15,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          carrierIn,
  input  histStrobe_t                   strobe,
  output cycleEvt_t                     evt,
  output logic [$clog2(HIST_LEN+1)-1:0] onesCount
);

  localparam int ONES_W = $clog2(HIST_LEN + 1);
  localparam logic [CNT_W-1:0] SAT_C = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PERIOD);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  // Input synchronizer chain
  logic [SYNC_DEPTH-1:0] syncChain;
  logic                  prevSync;
  logic                  riseNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      prevSync  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_DEPTH-2:0], carrierIn};
      prevSync  <= syncChain[SYNC_DEPTH-1];
    end
  end

  assign riseNow = syncChain[SYNC_DEPTH-1] & ~prevSync;

  // Period counter, saturating
  logic [CNT_W-1:0] periodCnt;
  logic             primed;
  logic             inWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      primed    <= 1'b0;
    end else if (riseNow) begin
      periodCnt <= ONE_C;
      primed    <= 1'b1;
    end else if (periodCnt != SAT_C) begin
      periodCnt <= periodCnt + ONE_C;
    end
  end

  assign inWindow = (periodCnt >= MIN_C) && (periodCnt <= MAX_C) && (periodCnt != SAT_C);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evt <= '0;
    end else begin
      evt.validEnd   <= riseNow & primed & inWindow;
      evt.invalidEnd <= riseNow & primed & ~inWindow;
    end
  end

  // Vote history
  logic [HIST_LEN-1:0] history;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      history <= '0;
    end else if (strobe.shiftEn) begin
      history <= {history[HIST_LEN-2:0], strobe.shiftBit};
    end
  end

  always_comb begin
    onesCount = '0;
    for (int i = 0; i < HIST_LEN; i++) begin
      onesCount = onesCount + ONES_W'(history[i]);
    end
  end

  // Assertions
  assert_count_saturates_R3: assert property (@(posedge clk) disable iff (!rstN)
    (periodCnt == SAT_C && !riseNow) |=> (periodCnt == SAT_C));

  assert_count_no_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(riseNow) && $past(periodCnt) != '0) |-> (periodCnt != '0));

  assert_valid_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    evt.validEnd |-> ($past(periodCnt) >= MIN_C && $past(periodCnt) <= MAX_C));

  assert_classify_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(evt.validEnd && evt.invalidEnd));

  assert_hist_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.shiftEn) |-> $stable(onesCount));

endmodule

// File: rtl/cwd_control.sv
module cwd_control
  import cwd_pkg::*;
#(
  parameter int SLOT_LEN    = 16,
  parameter int HIST_LEN    = 15,
  parameter int VOTE_THRESH = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cycleEvt_t                     evt,
  input  logic [$clog2(HIST_LEN+1)-1:0] onesCount,
  output histStrobe_t                   strobe,
  output logic                          detectN
);

  localparam int SLOT_W = $clog2(SLOT_LEN);
  localparam int ONES_W = $clog2(HIST_LEN + 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_LEN - 1);
  localparam logic [ONES_W-1:0] THRESH_C  = ONES_W'(VOTE_THRESH);
  localparam logic [ONES_W-1:0] HIST_C    = ONES_W'(HIST_LEN);

  // Reference slot timer
  logic [SLOT_W-1:0] slotCnt;
  logic              slotEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        slotCnt <= '0;
    else if (slotEnd) slotCnt <= '0;
    else              slotCnt <= slotCnt + SLOT_W'(1);
  end

  assign slotEnd = (slotCnt == SLOT_LAST);

  // Per-slot observation flags
  logic sawValid, sawInvalid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sawValid   <= 1'b0;
      sawInvalid <= 1'b0;
    end else if (slotEnd) begin
      sawValid   <= 1'b0;
      sawInvalid <= 1'b0;
    end else begin
      sawValid   <= sawValid   | evt.validEnd;
      sawInvalid <= sawInvalid | evt.invalidEnd;
    end
  end

  always_comb begin
    strobe.shiftEn  = slotEnd;
    strobe.shiftBit = (sawValid | evt.validEnd) & ~(sawInvalid | evt.invalidEnd);
  end

  // Majority decision with separate enter and leave thresholds
  detState_t state, stateNext;
  logic [ONES_W-1:0] zerosCount;

  assign zerosCount = HIST_C - onesCount;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (onesCount >= THRESH_C)  stateNext = ST_LOCKED;
      ST_LOCKED: if (zerosCount >= THRESH_C) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign detectN = (state != ST_LOCKED);

  // Assertions
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |-> detectN);

  assert_slot_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> !strobe.shiftEn);

  assert_vote_veto_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && evt.invalidEnd) |-> !strobe.shiftBit);

  assert_enter_majority_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(detectN) |-> ($past(onesCount) >= THRESH_C));

  assert_leave_majority_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detectN) |-> (HIST_C - $past(onesCount) >= THRESH_C));

endmodule

// File: rtl/carrier_window_detector.sv
module carrier_window_detector
  import cwd_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int MIN_PERIOD  = 14,
  parameter int MAX_PERIOD  = 18,
  parameter int SLOT_LEN    = 16,
  parameter int HIST_LEN    = 15,
  parameter int VOTE_THRESH = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic carrierIn,
  output logic detectN
);

  localparam int ONES_W = $clog2(HIST_LEN + 1);

  cycleEvt_t         evt;
  histStrobe_t       strobe;
  logic [ONES_W-1:0] onesCount;

  cwd_datapath #(
    .CNT_W      (CNT_W),
    .MIN_PERIOD (MIN_PERIOD),
    .MAX_PERIOD (MAX_PERIOD),
    .HIST_LEN   (HIST_LEN),
    .SYNC_DEPTH (2)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .carrierIn (carrierIn),
    .strobe    (strobe),
    .evt       (evt),
    .onesCount (onesCount)
  );

  cwd_control #(
    .SLOT_LEN    (SLOT_LEN),
    .HIST_LEN    (HIST_LEN),
    .VOTE_THRESH (VOTE_THRESH)
  ) uControl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .onesCount (onesCount),
    .strobe    (strobe),
    .detectN   (detectN)
  );

endmodule

// File: tb/tb_carrier_window_detector.sv
module tb_carrier_window_detector;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT       = 16;
  localparam int NROWS      = 9;
  localparam int PERIODS [NROWS] = '{13, 14, 15, 16, 17, 18, 19, 4, 48};
  localparam bit EXPECTS [NROWS] = '{0, 1, 1, 1, 1, 1, 0, 0, 0};
  localparam int NCYCLES    = 40;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic carrierIn = 1'b0;
  logic detectN;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int fallCyc = -1;
  int riseCyc = -1;
  int firstValidCyc = 0;
  int lastEdgeCyc = 0;
  bit monArmed = 1'b0;

  carrier_window_detector dut (
    .clk       (clk),
    .rstN      (rstN),
    .carrierIn (carrierIn),
    .detectN   (detectN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Transition monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (monArmed) begin
      if (detectN === 1'b0 && fallCyc < 0) fallCyc = cyc;
      if (fallCyc >= 0 && detectN === 1'b1 && riseCyc < 0) riseCyc = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    carrierIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Square wave of the given period; records the first in-window end and last edge
  task automatic drive(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      carrierIn = 1'b1;
      if (k == 1) firstValidCyc = cyc;
      if (k == n - 1) lastEdgeCyc = cyc;
      idle(p / 2);
      carrierIn = 1'b0;
      idle(p - p / 2);
    end
  endtask

  initial begin
    while (cyc < WATCHDOG) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
    summary();
  end

  initial begin
    // R1: reset state
    idle(2);
    check(detectN === 1'b1, "R1 during reset", int'(detectN), 1);
    doReset();
    idle(40);
    check(detectN === 1'b1, "R1 after release", int'(detectN), 1);

    // Stimulus table
    for (int r = 0; r < NROWS; r++) begin
      doReset();
      idle(40);
      fallCyc = -1;
      riseCyc = -1;
      monArmed = 1'b1;
      drive(PERIODS[r], NCYCLES);
      idle(20 * SLOT);
      monArmed = 1'b0;
      if (EXPECTS[r]) begin
        // R2 R5: in-window carrier is accepted within the latency bound
        check(fallCyc >= 0, $sformatf("R2 detect p=%0d", PERIODS[r]), fallCyc, 1);
        check(fallCyc - firstValidCyc >= 8 * SLOT && fallCyc - firstValidCyc <= 15 * SLOT + 8,
              $sformatf("R5 assert latency p=%0d", PERIODS[r]), fallCyc - firstValidCyc, 12 * SLOT);
        // R6: held while carrier on, released within bound after it stops
        check(riseCyc > lastEdgeCyc, $sformatf("R6 held p=%0d", PERIODS[r]), riseCyc, lastEdgeCyc);
        check(riseCyc - lastEdgeCyc >= 6 * SLOT && riseCyc - lastEdgeCyc <= 15 * SLOT + 8,
              $sformatf("R6 release latency p=%0d", PERIODS[r]), riseCyc - lastEdgeCyc, 10 * SLOT);
      end else begin
        // R2 R3 R7: out-of-window periods never assert
        check(fallCyc < 0, $sformatf("R7 no detect p=%0d", PERIODS[r]), fallCyc, -1);
        check(detectN === 1'b1, $sformatf("R3 idle after p=%0d", PERIODS[r]), int'(detectN), 1);
      end
    end

    // Directed: reset while locked returns to not-detected (R1)
    doReset();
    idle(40);
    drive(16, 20);
    check(detectN === 1'b0, "R5 locked before reset", int'(detectN), 0);
    rstN = 1'b0;
    idle(1);
    check(detectN === 1'b1, "R1 reset while locked", int'(detectN), 1);
    rstN = 1'b1;
    idle(20 * SLOT);
    check(detectN === 1'b1, "R1 history cleared", int'(detectN), 1);

    // Directed: carrier after reset needs full vote again (R4)
    fallCyc = -1;
    riseCyc = -1;
    monArmed = 1'b1;
    drive(16, 6);
    idle(2);
    check(fallCyc < 0, "R4 six cycles too few", fallCyc, -1);
    monArmed = 1'b0;

    summary();
  end

endmodule